// File: doc/BRIEF.md
# Timer Interrupt Vector Generator

This block collects the interrupt flags of a timer, one flag per compare channel plus one overflow flag, and turns them into two interrupt requests. Compare channel 0 drives its own request line, which has a vector of its own. Every other channel and the overflow flag share a second request line. For that shared line, a vector code reports which source the handler must serve.

The flags are held inside the block. One-cycle set pulses from the timer raise them. A flag is cleared in one of two ways. The channel-0 flag clears when the CPU acknowledges the dedicated request. A shared flag clears when the CPU reads the vector code, and only the flag named by that code is cleared. Repeated reads therefore walk through the pending shared sources in priority order.

The block also works out the 16-bit vector-table address of the winning request. It computes this from a priority number given as a parameter. The dedicated vector sits one priority step above the shared vector.

Top module: `timer_irq_vector`

## Requirements
- R1: After reset, all flags are clear, both request lines are low, the vector code is 0 and the vector address is 0.
- R2: A one-cycle set pulse on a source latches its flag. The flag is visible on the outputs from the cycle after the clock edge that samples the pulse.
- R3: The dedicated request is high exactly when the channel-0 flag is set, its enable is high and the global enable is high.
- R4: The shared request is high exactly when at least one shared flag is set with its own enable high and the global enable is high.
- R5: The vector code counts only shared flags whose enable is high, and it ignores the global enable. The code is 0 when none is pending, 2·n for compare channel n (1 ≤ n < NUM_CH), and 2·NUM_CH for the overflow flag. With the defaults (five channels) the codes are ch1=2, ch2=4, ch3=6, ch4=8 and overflow=10.
- R6: Among pending shared sources, the lower-numbered channel wins, and the overflow flag has the lowest priority.
- R7: A read strobe clears only the flag that the vector code reports in that cycle. A read while the code is 0 changes nothing, and a read never clears the channel-0 flag.
- R8: An acknowledge of the dedicated request clears the channel-0 flag.
- R9: The vector address is 0xFF80 + 2·priority. The shared vector uses priority SHARED_PRIO and the dedicated vector uses SHARED_PRIO+1. With the defaults these give 0xFFEA and 0xFFEC. The output shows the dedicated address whenever the dedicated request is high, otherwise the shared address when the shared request is high, and otherwise 0.
- R10: A set pulse arriving in the same cycle as a clear of the same flag leaves the flag set.
- R11: A flag whose enable is low stays pending and takes part once its enable is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chSet | input | NUM_CH | Set pulse per compare channel |
| ovfSet | input | 1 | Set pulse for overflow flag |
| chEn | input | NUM_CH | Enable per compare channel |
| ovfEn | input | 1 | Enable for overflow flag |
| globalEn | input | 1 | Global enable for maskable requests |
| ivRead | input | 1 | Read strobe of the vector code |
| dedAck | input | 1 | Acknowledge of the dedicated request |
| irqDedicated | output | 1 | Channel-0 request |
| irqShared | output | 1 | Shared request |
| ivValue | output | IV_W | Vector code of the highest pending shared source |
| vecAddr | output | 16 | Vector-table address of the winning request |

## Verification
The hardest case to reach is a collision on a single flag. One variant is a vector read that lands in the same cycle as a new set pulse for the flag being reported. The other is a read issued while channel 0 is pending and no shared source is. The bench produces both directly. It holds the read strobe and the set pulse high across the same clock edge. It then checks the resulting vector code and the request lines on the following cycle. Priority walking is exercised by raising three shared flags together, then reading repeatedly until the code drops back to 0.

// File: rtl/ivg_pkg.sv
package ivg_pkg;
  localparam int IDX_W = 8;
  localparam logic [15:0] TABLE_BASE = 16'hFF80;

  typedef struct packed {
    logic             clrDed;
    logic             clrShared;
    logic [IDX_W-1:0] sharedIdx;
  } ivgStrobe_t;

  function automatic logic [15:0] vecAddrOf(input int prio);
    return TABLE_BASE + 16'(2 * prio);
  endfunction
endpackage

// File: rtl/ivg_datapath.sv
module ivg_datapath
  import ivg_pkg::*;
#(
  parameter int NUM_CH = 5,
  localparam int NSRC = NUM_CH + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] setVec,
  input  ivgStrobe_t      strobe,
  output logic [NSRC-1:0] flags
);
  logic [NSRC-1:0] clrVec;

  always_comb begin
    clrVec    = '0;
    clrVec[0] = strobe.clrDed;
    for (int s = 1; s < NSRC; s++) begin
      clrVec[s] = strobe.clrShared && (int'(strobe.sharedIdx) == s);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~clrVec) | setVec;
  end

  for (genvar g = 0; g < NSRC; g++) begin : gChk
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      setVec[g] |=> flags[g]);
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rstN)
      (clrVec[g] && !setVec[g]) |=> !flags[g]);
    a_r11_pending_kept: assert property (@(posedge clk) disable iff (!rstN)
      (flags[g] && !clrVec[g]) |=> flags[g]);
  end
endmodule

// File: rtl/ivg_control.sv
module ivg_control
  import ivg_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int SHARED_PRIO = 53,
  localparam int NSRC = NUM_CH + 1,
  localparam int IV_W = $clog2(2 * NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   flags,
  input  logic [NUM_CH-1:0] chEn,
  input  logic              ovfEn,
  input  logic              globalEn,
  input  logic              ivRead,
  input  logic              dedAck,
  output ivgStrobe_t        strobe,
  output logic [IV_W-1:0]   ivValue,
  output logic              irqDed,
  output logic              irqShared,
  output logic [15:0]       vecAddr
);
  localparam logic [15:0] SHARED_ADDR = vecAddrOf(SHARED_PRIO);
  localparam logic [15:0] DED_ADDR    = vecAddrOf(SHARED_PRIO + 1);

  logic [NSRC-1:0]  pending;
  logic [IDX_W-1:0] winIdx;
  logic             found;

  assign pending = flags & {ovfEn, chEn};

  always_comb begin
    winIdx = '0;
    found  = 1'b0;
    for (int s = 1; s < NSRC; s++) begin
      if (!found && pending[s]) begin
        winIdx = IDX_W'(s);
        found  = 1'b1;
      end
    end
  end

  assign ivValue   = found ? IV_W'(2 * int'(winIdx)) : '0;
  assign irqDed    = pending[0] & globalEn;
  assign irqShared = (|pending[NSRC-1:1]) & globalEn;

  always_comb begin
    if (irqDed)         vecAddr = DED_ADDR;
    else if (irqShared) vecAddr = SHARED_ADDR;
    else                vecAddr = 16'h0000;
  end

  assign strobe.clrDed    = dedAck;
  assign strobe.clrShared = ivRead && found;
  assign strobe.sharedIdx = winIdx;

  a_r7_no_clear_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (ivValue == '0) |-> !strobe.clrShared);
endmodule

// File: rtl/timer_irq_vector.sv
module timer_irq_vector
  import ivg_pkg::*;
#(
  parameter int NUM_CH = 5,
  parameter int SHARED_PRIO = 53,
  localparam int IV_W = $clog2(2 * NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chSet,
  input  logic              ovfSet,
  input  logic [NUM_CH-1:0] chEn,
  input  logic              ovfEn,
  input  logic              globalEn,
  input  logic              ivRead,
  input  logic              dedAck,
  output logic              irqDedicated,
  output logic              irqShared,
  output logic [IV_W-1:0]   ivValue,
  output logic [15:0]       vecAddr
);
  ivgStrobe_t        strobe;
  logic [NUM_CH:0]   flags;

  ivg_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .setVec({ovfSet, chSet}),
    .strobe(strobe), .flags(flags)
  );

  ivg_control #(.NUM_CH(NUM_CH), .SHARED_PRIO(SHARED_PRIO)) u_ctl (
    .clk(clk), .rstN(rstN), .flags(flags), .chEn(chEn), .ovfEn(ovfEn),
    .globalEn(globalEn), .ivRead(ivRead), .dedAck(dedAck), .strobe(strobe),
    .ivValue(ivValue), .irqDed(irqDedicated), .irqShared(irqShared),
    .vecAddr(vecAddr)
  );

  a_r8_ack_drops_ded: assert property (@(posedge clk) disable iff (!rstN)
    (dedAck && !chSet[0]) |=> !irqDedicated);
  a_r9_ded_addr: assert property (@(posedge clk) disable iff (!rstN)
    irqDedicated |-> (vecAddr == vecAddrOf(SHARED_PRIO + 1)));
endmodule

// File: tb/timer_irq_vector_tb.sv
module timer_irq_vector_tb;
  localparam int NCH = 5;
  localparam logic [15:0] SH_ADDR  = 16'hFFEA;
  localparam logic [15:0] DED_ADDR = 16'hFFEC;

  logic clk = 0, rstN = 0;
  logic [NCH-1:0] chSet = '0, chEn = '1;
  logic ovfSet = 0, ovfEn = 1, globalEn = 1, ivRead = 0, dedAck = 0;
  logic irqDedicated, irqShared;
  logic [3:0] ivValue;
  logic [15:0] vecAddr;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  timer_irq_vector #(.NUM_CH(NCH), .SHARED_PRIO(53)) u_dut (
    .clk(clk), .rstN(rstN), .chSet(chSet), .ovfSet(ovfSet), .chEn(chEn),
    .ovfEn(ovfEn), .globalEn(globalEn), .ivRead(ivRead), .dedAck(dedAck),
    .irqDedicated(irqDedicated), .irqShared(irqShared), .ivValue(ivValue),
    .vecAddr(vecAddr)
  );

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [NCH-1:0] s, input logic o, input logic rd, input logic ack);
    @(negedge clk);
    chSet = s; ovfSet = o; ivRead = rd; dedAck = ack;
    @(negedge clk);
    chSet = '0; ovfSet = 0; ivRead = 0; dedAck = 0;
  endtask

  task automatic clearAll();
    rstN = 0; @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  task automatic tReset();
    clearAll();
    check("R1 irqDed", irqDedicated, 0);
    check("R1 irqShared", irqShared, 0);
    check("R1 iv", ivValue, 0);
    check("R1 addr", vecAddr, 0);
  endtask

  task automatic tSingle();
    clearAll();
    tick(5'b00100, 0, 0, 0);
    check("R2 R5 iv ch2", ivValue, 4);
    check("R4 irqShared", irqShared, 1);
    check("R9 shared addr", vecAddr, SH_ADDR);
    tick('0, 1, 1, 0);
    check("R5 iv ovf after ch2 read", ivValue, 10);
  endtask

  task automatic tPriority();
    clearAll();
    tick(5'b01010, 1, 0, 0);
    check("R6 ch1 first", ivValue, 2);
    tick('0, 0, 1, 0);
    check("R7 R6 ch3 next", ivValue, 6);
    tick('0, 0, 1, 0);
    check("R7 R6 ovf last", ivValue, 10);
    tick('0, 0, 1, 0);
    check("R7 empty", ivValue, 0);
    check("R4 no shared", irqShared, 0);
    check("R9 addr zero", vecAddr, 0);
  endtask

  task automatic tMask();
    clearAll();
    chEn = 5'b11011;
    tick(5'b00100, 0, 0, 0);
    check("R5 masked iv", ivValue, 0);
    check("R4 masked irq", irqShared, 0);
    tick('0, 0, 1, 0);
    chEn = '1;
    @(negedge clk);
    check("R11 unmasked iv", ivValue, 4);
  endtask

  task automatic tGlobal();
    clearAll();
    globalEn = 0;
    tick(5'b10001, 0, 0, 0);
    check("R3 ded gated", irqDedicated, 0);
    check("R4 shared gated", irqShared, 0);
    check("R5 iv ignores global", ivValue, 8);
    globalEn = 1;
    @(negedge clk);
    check("R3 ded on", irqDedicated, 1);
    chEn[0] = 0;
    @(negedge clk);
    check("R3 ded masked", irqDedicated, 0);
    chEn[0] = 1;
  endtask

  task automatic tDed();
    clearAll();
    tick(5'b00011, 0, 0, 0);
    check("R3 ded", irqDedicated, 1);
    check("R9 ded addr wins", vecAddr, DED_ADDR);
    tick('0, 0, 1, 0);
    check("R7 read keeps ch0", irqDedicated, 1);
    check("R7 ch1 cleared", ivValue, 0);
    tick('0, 0, 1, 0);
    check("R7 empty read keeps ch0", irqDedicated, 1);
    tick('0, 1, 0, 1);
    check("R8 ack clears", irqDedicated, 0);
    check("R9 back to shared", vecAddr, SH_ADDR);
  endtask

  task automatic tSetWins();
    clearAll();
    tick(5'b00010, 0, 0, 0);
    tick(5'b00010, 0, 1, 0);
    check("R10 set beats read", ivValue, 2);
    tick(5'b00001, 0, 0, 1);
    check("R10 set beats ack", irqDedicated, 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tReset();
    tSingle();
    tPriority();
    tMask();
    tGlobal();
    tDed();
    tSetWins();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule